// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a list of up to sixteen transfers with no help from a processor between them. Each list slot holds a transmit word, a length code, a four-bit chip-select pattern and a flag that keeps the select asserted into the following slot. After a start pulse the sequencer fetches slot 0 and drives its select pattern. It waits a programmable lead time, clocks the word out MSB first while capturing the input line, and then waits a programmable trail time. It stores the captured word in the receive list at the same index and moves to the next slot.

Clock polarity, clock phase and the serial clock divider are shared by all slots. The four select outputs carry an encoded value, so all-ones means "no device" and fifteen other codes remain for peripherals. Normally the run stops after the slot named by the end pointer and raises a done flag. With looping enabled the sequencer goes back to slot 0 and keeps cycling until a halt request lets it finish at the end pointer.

Top module: `spi_queue_master`

## Requirements
- R1: Out of reset and whenever idle, `cs_n` is 4'hF, `sck` equals `cpol`, and `busy` and `done` are low.
- R2: A start pulse while idle runs slots 0 through `end_ptr` in ascending order. During the clocking of each slot, `cs_n` carries that slot's select pattern.
- R3: The transfer length is 8 plus the slot's 4-bit length code, with codes above 8 treated as 16 bits. Bit (length-1) of the transmit word is sent first on `mosi`, and bits above the length are not sent.
- R4: The captured word is stored right-justified in the receive list at the slot's index and can be read through `rx_raddr`/`rx_rdata`.
- R5: Every half period of `sck` lasts max(`div`,4) clock cycles.
- R6: With `cpha`=0, data is sampled on the first (leading) edge of each bit. With `cpha`=1, it is sampled on the second (trailing) edge. Sampling is therefore on the rising edge of `sck` exactly when `cpol` equals `cpha`.
- R7: The first `sck` edge comes `pre_dly`+1+max(`div`,4) cycles after the slot's select pattern appears.
- R8: A select that is not held is released (4'hF) `post_dly`+2 cycles after the last `sck` edge of the slot.
- R9: A slot with the hold flag set leaves the select asserted into the next slot. The last slot of a stopping run always releases it.
- R10: A stopping run lowers `busy` and raises `done` in the same cycle. `done` clears at the next start and is never high while `busy` is.
- R11: With `wrap_en` set, slot 0 follows slot `end_ptr` and `done` stays low. Raising `halt` makes the run stop after the next completion of slot `end_ptr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command list |
| cmd_waddr | input | 4 | Slot written |
| cmd_tx | input | 16 | Transmit word for the slot |
| cmd_len | input | 4 | Length code (bits = 8 + code, max 16) |
| cmd_cs | input | 4 | Encoded select pattern for the slot |
| cmd_hold | input | 1 | Keep select asserted into the next slot |
| rx_raddr | input | 4 | Receive list read index |
| rx_rdata | output | 16 | Receive list read data |
| start | input | 1 | Start pulse, taken while idle |
| halt | input | 1 | Stop a looping run at the end pointer |
| end_ptr | input | 4 | Index of the last slot |
| wrap_en | input | 1 | Loop back to slot 0 after the end pointer |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Sampling edge select |
| div | input | 8 | Half-period length in clocks (clamped to at least 4) |
| pre_dly | input | 8 | Lead time before the first clock edge |
| post_dly | input | 8 | Trail time after the last clock edge |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Encoded select lines, 4'hF when none |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last stopping run has finished |

## Verification
The checker assumes that `div`, `cpol`, `cpha`, the delays, `end_ptr` and the list contents stay fixed while `busy` is high. It also assumes that a change of `div` while idle is followed by at least one idle cycle before the next start. Its half-period bound only applies while the divider is steady. The bench writes every slot and changes every setting only between runs, after `done` has risen. It loops `mosi` back into `miso`, so each captured word can be predicted from the transmit word and the length alone.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SQ_DW       = 16;            // widest transfer
  localparam int SQ_DEPTH    = 16;            // list slots
  localparam int SQ_AW       = $clog2(SQ_DEPTH);
  localparam int SQ_CSW      = 4;             // encoded select width
  localparam int SQ_LW       = 4;             // length code width
  localparam int SQ_CW       = 8;             // divider / delay width
  localparam int SQ_MIN_DIV  = 4;
  localparam int SQ_MIN_BITS = 8;
  localparam int SQ_BCW      = $clog2(SQ_DW + 1);
  localparam int SQ_EW       = SQ_BCW + 1;    // edge index width

  typedef struct packed {
    logic [SQ_DW-1:0]  tx;
    logic [SQ_LW-1:0]  len;
    logic [SQ_CSW-1:0] cs;
    logic              hold;
  } sq_cmd_t;

  localparam int SQ_CMDW = $bits(sq_cmd_t);

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LOAD, SQ_PRE, SQ_SHIFT, SQ_POST, SQ_NEXT
  } sq_state_t;

  // number of bits moved for a length code
  function automatic logic [SQ_BCW-1:0] sq_nbits(input logic [SQ_LW-1:0] code);
    int n;
    n = SQ_MIN_BITS + int'(code);
    if (n > SQ_DW) n = SQ_DW;
    return SQ_BCW'(n);
  endfunction

  // half period actually used
  function automatic logic [SQ_CW-1:0] sq_eff_div(input logic [SQ_CW-1:0] d);
    return (d < SQ_CW'(SQ_MIN_DIV)) ? SQ_CW'(SQ_MIN_DIV) : d;
  endfunction

  // move the first bit to be sent into the top position
  function automatic logic [SQ_DW-1:0] sq_align(input logic [SQ_DW-1:0] w,
                                                input logic [SQ_BCW-1:0] nb);
    return w << (SQ_DW - int'(nb));
  endfunction
endpackage

// File: rtl/sq_ram.sv
module sq_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sq_baud.sv
module sq_baud
  import sq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SQ_CW-1:0] div_eff,
  output logic             edge_pulse,
  output logic [SQ_CW-1:0] halfcnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     halfcnt <= SQ_CW'(SQ_MIN_DIV - 1);
    else if (!run || halfcnt == '0) halfcnt <= div_eff - SQ_CW'(1);
    else                            halfcnt <= halfcnt - SQ_CW'(1);
  end

  assign edge_pulse = run && (halfcnt == '0);
endmodule

// File: rtl/sq_shifter.sv
module sq_shifter
  import sq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SQ_DW-1:0]  load_word,
  input  logic [SQ_BCW-1:0] nbits,
  input  logic              edge_pulse,
  input  logic              cpha,
  input  logic              miso,
  output logic              mosi,
  output logic [SQ_DW-1:0]  rx_word,
  output logic              sck_int,
  output logic              last_edge
);
  logic [SQ_DW-1:0] sh;
  logic [SQ_EW-1:0] idx;
  logic [SQ_EW-1:0] last_idx;
  logic             sample_now;
  logic             shift_now;

  // even index = leading edge of a bit
  assign sample_now = (~idx[0]) ^ cpha;
  assign shift_now  = !sample_now && !(cpha && idx == '0);
  assign last_idx   = SQ_EW'({nbits, 1'b0}) - SQ_EW'(1);
  assign last_edge  = edge_pulse && (idx == last_idx);
  assign mosi       = sh[SQ_DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      rx_word <= '0;
      idx     <= '0;
      sck_int <= 1'b0;
    end else if (load) begin
      sh      <= load_word;
      rx_word <= '0;
      idx     <= '0;
      sck_int <= 1'b0;
    end else if (edge_pulse) begin
      sck_int <= ~sck_int;
      idx     <= idx + SQ_EW'(1);
      if (sample_now)     rx_word <= {rx_word[SQ_DW-2:0], miso};
      else if (shift_now) sh      <= {sh[SQ_DW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import sq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [SQ_AW-1:0]  cmd_waddr,
  input  logic [SQ_DW-1:0]  cmd_tx,
  input  logic [SQ_LW-1:0]  cmd_len,
  input  logic [SQ_CSW-1:0] cmd_cs,
  input  logic              cmd_hold,
  input  logic [SQ_AW-1:0]  rx_raddr,
  output logic [SQ_DW-1:0]  rx_rdata,
  input  logic              start,
  input  logic              halt,
  input  logic [SQ_AW-1:0]  end_ptr,
  input  logic              wrap_en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [SQ_CW-1:0]  div,
  input  logic [SQ_CW-1:0]  pre_dly,
  input  logic [SQ_CW-1:0]  post_dly,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [SQ_CSW-1:0] cs_n,
  output logic              busy,
  output logic              done
);
  localparam logic [SQ_CSW-1:0] CS_NONE = '1;

  sq_state_t         state;
  logic [SQ_AW-1:0]  ptr;
  logic [SQ_CW-1:0]  cnt;
  logic [SQ_CSW-1:0] cs_q;
  sq_cmd_t           entry;
  sq_cmd_t           wr_entry;
  logic [SQ_BCW-1:0] nbits_e;
  logic [SQ_CW-1:0]  div_eff;
  logic [SQ_CW-1:0]  halfcnt;
  logic [SQ_DW-1:0]  rx_word;
  logic              edge_pulse, last_edge, sck_int;
  logic              shifting, at_end, stop_here, rx_we;

  assign wr_entry = '{tx: cmd_tx, len: cmd_len, cs: cmd_cs, hold: cmd_hold};
  assign nbits_e  = sq_nbits(entry.len);
  assign div_eff  = sq_eff_div(div);
  assign shifting = (state == SQ_SHIFT);
  assign at_end   = (ptr == end_ptr);
  assign stop_here = at_end && !(wrap_en && !halt);
  assign rx_we    = (state == SQ_NEXT);

  sq_ram #(.W(SQ_CMDW), .DEPTH(SQ_DEPTH)) u_cmd_ram (
    .clk(clk), .we(cmd_we), .waddr(cmd_waddr), .wdata(wr_entry),
    .raddr(ptr), .rdata(entry)
  );

  sq_ram #(.W(SQ_DW), .DEPTH(SQ_DEPTH)) u_rx_ram (
    .clk(clk), .we(rx_we), .waddr(ptr), .wdata(rx_word),
    .raddr(rx_raddr), .rdata(rx_rdata)
  );

  sq_baud u_baud (
    .clk(clk), .rst_n(rst_n), .run(shifting), .div_eff(div_eff),
    .edge_pulse(edge_pulse), .halfcnt(halfcnt)
  );

  sq_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(state == SQ_LOAD),
    .load_word(sq_align(entry.tx, nbits_e)), .nbits(nbits_e),
    .edge_pulse(edge_pulse), .cpha(cpha), .miso(miso), .mosi(mosi),
    .rx_word(rx_word), .sck_int(sck_int), .last_edge(last_edge)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      ptr   <= '0;
      cnt   <= '0;
      cs_q  <= CS_NONE;
      done  <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          ptr   <= '0;
          done  <= 1'b0;
          state <= SQ_LOAD;
        end
        SQ_LOAD: begin
          cs_q  <= entry.cs;
          cnt   <= pre_dly;
          state <= SQ_PRE;
        end
        SQ_PRE: begin
          if (cnt == '0) state <= SQ_SHIFT;
          else           cnt   <= cnt - SQ_CW'(1);
        end
        SQ_SHIFT: if (last_edge) begin
          cnt   <= post_dly;
          state <= SQ_POST;
        end
        SQ_POST: begin
          if (cnt == '0) state <= SQ_NEXT;
          else           cnt   <= cnt - SQ_CW'(1);
        end
        SQ_NEXT: begin
          if (stop_here) begin
            cs_q  <= CS_NONE;
            done  <= 1'b1;
            state <= SQ_IDLE;
          end else begin
            if (!entry.hold) cs_q <= CS_NONE;
            ptr   <= at_end ? '0 : ptr + SQ_AW'(1);
            state <= SQ_LOAD;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign sck  = cpol ^ sck_int;
  assign cs_n = cs_q;
  assign busy = (state != SQ_IDLE);
endmodule

// File: rtl/sq_checker.sv
module sq_checker
  import sq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [SQ_CSW-1:0] cs_n,
  input logic              sck,
  input logic              cpol,
  input logic              shifting,
  input logic              edge_pulse,
  input logic [SQ_CW-1:0]  halfcnt,
  input logic [SQ_CW-1:0]  div_eff
);
  assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n == '1);

  assert_idle_sck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> sck == cpol);

  assert_cs_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && $past(shifting)) |-> $stable(cs_n));

  assert_edge_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);

  assert_half_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $stable(div_eff)) |-> halfcnt < div_eff);

  assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_done_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));
endmodule

bind spi_queue_master sq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cs_n(cs_n),
  .sck(sck), .cpol(cpol), .shifting(shifting), .edge_pulse(edge_pulse),
  .halfcnt(halfcnt), .div_eff(div_eff)
);

// File: tb/tb_spi_queue_master.sv
module tb_spi_queue_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0, cmd_hold = 1'b0;
  logic [3:0]  cmd_waddr = '0, cmd_len = '0, cmd_cs = '0, rx_raddr = '0, end_ptr = '0;
  logic [15:0] cmd_tx = '0;
  logic [15:0] rx_rdata;
  logic        start = 1'b0, halt = 1'b0, wrap_en = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [7:0]  div = 8'd4, pre_dly = '0, post_dly = '0;
  logic        sck, mosi, miso, busy, done;
  logic [3:0]  cs_n;

  int checks = 0, failures = 0;

  assign miso = mosi;  // loopback

  spi_queue_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_waddr(cmd_waddr),
    .cmd_tx(cmd_tx), .cmd_len(cmd_len), .cmd_cs(cmd_cs), .cmd_hold(cmd_hold),
    .rx_raddr(rx_raddr), .rx_rdata(rx_rdata), .start(start), .halt(halt),
    .end_ptr(end_ptr), .wrap_en(wrap_en), .cpol(cpol), .cpha(cpha),
    .div(div), .pre_dly(pre_dly), .post_dly(post_dly), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;  // 50 MHz

  // ---------------- bus monitor ----------------
  time        t_cs_on, t_cs_off, t_first, t_last;
  int         seg_edges, ncap, cs_on_count, min_half, max_half, pat_n;
  logic [15:0] cap;
  logic [3:0] pat_log [16];
  logic [3:0] last_on;
  logic [3:0] prev_cs = 4'hF;

  always @(cs_n) begin
    if (!$isunknown(cs_n)) begin
      if (pat_n < 16) begin pat_log[pat_n] = cs_n; pat_n++; end
      if (cs_n != 4'hF && prev_cs == 4'hF) begin
        t_cs_on = $time; seg_edges = 0; cs_on_count++; last_on = cs_n;
      end
      if (cs_n == 4'hF && prev_cs != 4'hF) t_cs_off = $time;
      prev_cs = cs_n;
    end
  end

  always @(sck) begin
    if (!$isunknown(sck) && cs_n != 4'hF && !$isunknown(cs_n)) begin
      if (seg_edges == 0) t_first = $time;
      else begin
        int g;
        g = int'(($time - t_last) / 20);
        if (g < min_half) min_half = g;
        if (g > max_half) max_half = g;
      end
      t_last = $time;
      seg_edges++;
      if (sck == (cpol == cpha)) begin cap = {cap[14:0], mosi}; ncap++; end
    end
  end

  task automatic clear_mon();
    seg_edges = 0; ncap = 0; cs_on_count = 0; cap = '0; pat_n = 0;
    min_half = 1000000; max_half = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] tx, input logic [3:0] len,
                     input logic [3:0] cs, input logic hold);
    @(negedge clk);
    cmd_we = 1'b1; cmd_waddr = 4'(a); cmd_tx = tx; cmd_len = len; cmd_cs = cs; cmd_hold = hold;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic run_q();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] rx_read_dummy(input int x); return 32'(x); endfunction

  task automatic rx_at(input int a, output logic [15:0] v);
    @(negedge clk); rx_raddr = 4'(a); #1 v = rx_rdata;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(cs_n == 4'hF, "R1 cs idle", cs_n, 4'hF);
    chk(sck == cpol && busy == 1'b0 && done == 1'b0, "R1 sck/busy/done", {sck, busy, done}, 0);
  endtask

  task automatic t_mode0();
    logic [15:0] v;
    cpol = 0; cpha = 0; div = 8'd4; pre_dly = 8'd3; post_dly = 8'd2; end_ptr = 0; wrap_en = 0;
    put(0, 16'h00A5, 4'd0, 4'h6, 1'b0);
    clear_mon(); run_q();
    rx_at(0, v);
    chk(v == 16'h00A5, "R4 rx mode0", v, 16'h00A5);
    chk(cap == 16'h00A5 && ncap == 8, "R3 mosi 8 bits", {ncap[15:0], cap}, {16'd8, 16'h00A5});
    chk(last_on == 4'h6, "R2 cs pattern", last_on, 4'h6);
    chk((t_first - t_cs_on) / 20 == 8, "R7 lead time", int'((t_first - t_cs_on) / 20), 8);
    chk(min_half == 4 && max_half == 4, "R5 half period", {min_half[15:0], max_half[15:0]}, {16'd4, 16'd4});
    chk((t_cs_off - t_last) / 20 == 4, "R8 trail time", int'((t_cs_off - t_last) / 20), 4);
    chk(done && !busy && sck == 1'b0, "R10 done after run", {done, busy, sck}, 3'b100);
  endtask

  task automatic t_mode3_long();
    logic [15:0] v;
    cpol = 1; cpha = 1; div = 8'd5; pre_dly = 0; post_dly = 0;
    put(0, 16'hBEEF, 4'hF, 4'hE, 1'b0);  // code 15 clamps to 16 bits
    @(negedge clk);
    chk(sck == 1'b1, "R1 sck idles at cpol=1", sck, 1);
    clear_mon(); run_q();
    rx_at(0, v);
    chk(v == 16'hBEEF, "R4 rx mode3", v, 16'hBEEF);
    chk(cap == 16'hBEEF && ncap == 16, "R3 R6 16-bit clamp mode3", {ncap[15:0], cap}, {16'd16, 16'hBEEF});
    chk((t_first - t_cs_on) / 20 == 6, "R7 lead zero", int'((t_first - t_cs_on) / 20), 6);
    chk(min_half == 5 && max_half == 5, "R5 half five", {min_half[15:0], max_half[15:0]}, {16'd5, 16'd5});
    chk((t_cs_off - t_last) / 20 == 2, "R8 trail zero", int'((t_cs_off - t_last) / 20), 2);
  endtask

  task automatic t_odd_lengths();
    logic [15:0] v;
    cpol = 0; cpha = 1; div = 8'd4; pre_dly = 1; post_dly = 1;
    put(0, 16'hFDA3, 4'd3, 4'h2, 1'b0);  // 11 bits
    clear_mon(); run_q();
    rx_at(0, v);
    chk(v == 16'h05A3, "R4 rx 11-bit mode1", v, 16'h05A3);
    chk(cap == 16'h05A3 && ncap == 11, "R3 R6 11 bits mode1", {ncap[15:0], cap}, {16'd11, 16'h05A3});
    cpol = 1; cpha = 0;
    put(0, 16'hF234, 4'd5, 4'h2, 1'b0);  // 13 bits
    clear_mon(); run_q();
    rx_at(0, v);
    chk(v == 16'h1234, "R4 rx 13-bit mode2", v, 16'h1234);
    chk(cap == 16'h1234 && ncap == 13, "R3 R6 13 bits mode2", {ncap[15:0], cap}, {16'd13, 16'h1234});
  endtask

  task automatic t_div_clamp();
    cpol = 0; cpha = 0; div = 8'd2; pre_dly = 0; post_dly = 0;
    put(0, 16'h003C, 4'd0, 4'h1, 1'b0);
    @(negedge clk);
    clear_mon(); run_q();
    chk(min_half == 4 && max_half == 4, "R5 divider clamp", {min_half[15:0], max_half[15:0]}, {16'd4, 16'd4});
    chk((t_first - t_cs_on) / 20 == 5, "R7 lead with clamp", int'((t_first - t_cs_on) / 20), 5);
  endtask

  task automatic t_queue_hold();
    logic [15:0] v;
    div = 8'd4; pre_dly = 2; post_dly = 1; end_ptr = 4'd2;
    put(0, 16'h0011, 4'd0, 4'h3, 1'b1);
    put(1, 16'h2222, 4'd8, 4'h3, 1'b0);
    put(2, 16'h00F0, 4'd4, 4'h9, 1'b0);
    clear_mon(); run_q();
    chk(cs_on_count == 2, "R9 hold keeps select", cs_on_count, 2);
    chk(pat_n == 4 && pat_log[0] == 4'h3 && pat_log[1] == 4'hF && pat_log[2] == 4'h9 && pat_log[3] == 4'hF,
        "R2 select order", {pat_log[0], pat_log[1], pat_log[2], pat_log[3]}, 16'h3F9F);
    rx_at(0, v); chk(v == 16'h0011, "R4 slot0", v, 16'h0011);
    rx_at(1, v); chk(v == 16'h2222, "R4 slot1", v, 16'h2222);
    rx_at(2, v); chk(v == 16'h00F0, "R4 slot2", v, 16'h00F0);
    chk(done && !busy, "R10 list done", {done, busy}, 2'b10);
  endtask

  task automatic t_wrap();
    pre_dly = 0; post_dly = 0; end_ptr = 4'd1; wrap_en = 1;
    put(0, 16'h0081, 4'd0, 4'h1, 1'b0);
    put(1, 16'h0042, 4'd0, 4'h2, 1'b0);
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && busy, "R10 start clears done", {done, busy}, 2'b01);
    for (int i = 0; i < 20000 && cs_on_count < 5; i++) @(negedge clk);
    chk(cs_on_count >= 5 && !done && busy, "R11 looping continues", cs_on_count, 5);
    halt = 1'b1;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    halt = 1'b0;
    chk(done && last_on == 4'h2 && cs_on_count % 2 == 0, "R11 halt ends at end pointer",
        {cs_on_count[7:0], last_on}, 4'h2);
    wrap_en = 0;
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode3_long();
    t_odd_lengths();
    t_div_clamp();
    t_queue_hold();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=busy expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule